// File: doc/BRIEF.md
# Masked Prefix Count Unit

This block turns a short bit vector (up to eight elements) into a vector of running counts, one count per element, in a single registered step. It is meant to sit beside a vector register file: the caller presents the source bits, a predicate mask, the active length and the destination's old contents, pulses a start strobe, and one cycle later receives the new per-element values with a write enable for each element.

Two modes are offered. The prefix mode gives each active element the number of qualifying source bits that lie strictly below its own position. A qualifying bit is set in the source and also set in the mask. A flag can replace the source with all ones, which turns the output into the index sequence 0, 1, 2 and so on. The resetting mode walks the elements in ascending order with a counter. Each active element receives the counter value, and the counter then steps when one selected bit of that element's 4-bit condition nibble equals a polarity bit. An inactive element zeroes the counter.

Top module: `prefix_count_unit`

## Requirements
- R1: After reset, valid_o is 0, wen_o is all zeros and result_o is all zeros.
- R2: valid_o is 1 in exactly the cycle after a cycle with start_i high, and 0 otherwise.
- R3: With mode_i=0 and the mask all ones, element i (packed at result_o[4*i +: 4]) holds the number of set source bits at positions below i; source 8'b1001_0001 gives elements 7..0 = 2,2,2,1,1,1,1,0.
- R4: With mode_i=0 and src_all_ones_i=1, the source is taken as all ones, so active element i receives i (the sequence 0..VL-1 when unmasked).
- R5: With mode_i=0 and a mask, only source bits whose mask bit is 1 are counted, and an element whose mask bit is 0 has wen_o low and result equal to its prev_i value; mask 8'b1110_1011, source 8'b1001_0001 and previous 2,3,4,5,6,7,8,9 give 1,1,1,5,1,7,1,0.
- R6: An element whose index is at or above vl_i (1..8) is never written: its wen_o bit is 0 and its result equals its prev_i value, in both modes.
- R7: With mode_i=1, each active element is written with the running count before any update, then the count increments when bit sel_i of that element's nibble cond_i[4*i +: 4] equals pol_i; the count starts at 0.
- R8: With mode_i=1, an element whose mask bit is 0 is not written (result equals prev_i) and sets the running count back to zero for the following elements.
- R9: In a cycle with valid_o low, wen_o is all zeros.
- R10: result_o keeps its value in every cycle that does not follow a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe; operands sampled with it |
| mode_i | input | 1 | 0 = prefix count, 1 = resetting count |
| src_all_ones_i | input | 1 | Prefix mode: treat the source as all ones |
| src_bits_i | input | 8 | Source bit per element (bit i = element i) |
| mask_i | input | 8 | Predicate: 1 = element active |
| vl_i | input | 4 | Active vector length, 1..8 |
| cond_i | input | 32 | Resetting mode: 4-bit condition nibble per element |
| sel_i | input | 2 | Resetting mode: which nibble bit is tested |
| pol_i | input | 1 | Resetting mode: value the tested bit must equal |
| prev_i | input | 32 | Destination's previous element values, 4 bits each |
| valid_o | output | 1 | Result valid, one cycle after start |
| wen_o | output | 8 | Per-element write enable, qualified by valid_o |
| result_o | output | 32 | Per-element results, element i at [4*i +: 4] |

## Verification
Every result, write enable and the valid flag are due exactly one clock after the edge that samples start_i, since one register stage lies between the operands and the outputs. The bench raises start_i at a falling edge, lowers it at the next falling edge, and reads the outputs at that same falling edge, half a period after the capturing edge. It then reads again one period later to see valid_o and wen_o drop while result_o holds. Expected values come from a model in the bench written from the requirements, and literal vectors cover the worked examples.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int unsigned NIB_W = 4;

    typedef enum logic {
        MODE_PREFIX = 1'b0,
        MODE_RESET  = 1'b1
    } pcu_mode_e;
endpackage

// File: rtl/pcu_prefix.sv
module pcu_prefix #(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned CNT_W    = 4
) (
    input  logic [NUM_ELEM-1:0]       bits_i,
    output logic [NUM_ELEM*CNT_W-1:0] cnt_o
);
    // each element sums the qualifying bits strictly below it
    for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_el
        logic [CNT_W-1:0] sum;
        always_comb begin
            sum = '0;
            for (int j = 0; j < gi; j++) begin
                sum = sum + CNT_W'(bits_i[j]);
            end
        end
        assign cnt_o[gi*CNT_W +: CNT_W] = sum;
    end
endmodule

// File: rtl/pcu_chain.sv
module pcu_chain
    import pcu_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned VL_W     = 4
) (
    input  logic [NUM_ELEM-1:0]       mask_i,
    input  logic [VL_W-1:0]           vl_i,
    input  logic [NUM_ELEM*NIB_W-1:0] cond_i,
    input  logic [1:0]                sel_i,
    input  logic                      pol_i,
    output logic [NUM_ELEM*CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] run;
    logic [NIB_W-1:0] nib;

    always_comb begin
        run   = '0;
        nib   = '0;
        cnt_o = '0;
        for (int k = 0; k < NUM_ELEM; k++) begin
            if (VL_W'(k) < vl_i) begin
                if (mask_i[k]) begin
                    nib = cond_i[k*NIB_W +: NIB_W];
                    cnt_o[k*CNT_W +: CNT_W] = run;
                    if (nib[sel_i] == pol_i) begin
                        run = run + 1'b1;
                    end
                end else begin
                    run = '0;
                end
            end
        end
    end
endmodule

// File: rtl/prefix_count_unit.sv
module prefix_count_unit
    import pcu_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned CNT_W    = 4,
    localparam int unsigned VL_W    = $clog2(NUM_ELEM + 1),
    localparam int unsigned RES_W   = NUM_ELEM * CNT_W,
    localparam int unsigned COND_W  = NUM_ELEM * NIB_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              src_all_ones_i,
    input  logic [NUM_ELEM-1:0] src_bits_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic [1:0]        sel_i,
    input  logic              pol_i,
    input  logic [RES_W-1:0]  prev_i,
    output logic              valid_o,
    output logic [NUM_ELEM-1:0] wen_o,
    output logic [RES_W-1:0]  result_o
);
    typedef struct packed {
        logic                valid;
        logic [NUM_ELEM-1:0] wen;
        logic [RES_W-1:0]    res;
    } pcu_state_t;

    pcu_state_t state_d, state_q;

    logic [NUM_ELEM-1:0] qual_bits;
    logic [NUM_ELEM-1:0] active;
    logic [RES_W-1:0]    prefix_cnt;
    logic [RES_W-1:0]    chain_cnt;
    pcu_mode_e           mode;

    assign mode      = pcu_mode_e'(mode_i);
    assign qual_bits = (src_all_ones_i ? {NUM_ELEM{1'b1}} : src_bits_i) & mask_i;

    always_comb begin
        for (int k = 0; k < NUM_ELEM; k++) begin
            active[k] = mask_i[k] && (VL_W'(k) < vl_i);
        end
    end

    pcu_prefix #(
        .NUM_ELEM(NUM_ELEM),
        .CNT_W   (CNT_W)
    ) u_prefix (
        .bits_i(qual_bits),
        .cnt_o (prefix_cnt)
    );

    pcu_chain #(
        .NUM_ELEM(NUM_ELEM),
        .CNT_W   (CNT_W),
        .VL_W    (VL_W)
    ) u_chain (
        .mask_i(mask_i),
        .vl_i  (vl_i),
        .cond_i(cond_i),
        .sel_i (sel_i),
        .pol_i (pol_i),
        .cnt_o (chain_cnt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = start_i;
        state_d.wen   = '0;
        if (start_i) begin
            for (int k = 0; k < NUM_ELEM; k++) begin
                if (active[k]) begin
                    state_d.wen[k] = 1'b1;
                    state_d.res[k*CNT_W +: CNT_W] = (mode == MODE_RESET)
                        ? chain_cnt[k*CNT_W +: CNT_W]
                        : prefix_cnt[k*CNT_W +: CNT_W];
                end else begin
                    state_d.res[k*CNT_W +: CNT_W] = prev_i[k*CNT_W +: CNT_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_o  = state_q.valid;
    assign wen_o    = state_q.wen;
    assign result_o = state_q.res;
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned CNT_W    = 4,
    localparam int unsigned VL_W    = $clog2(NUM_ELEM + 1)
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      start_i,
    input logic [NUM_ELEM-1:0]       mask_i,
    input logic [VL_W-1:0]           vl_i,
    input logic                      valid_o,
    input logic [NUM_ELEM-1:0]       wen_o,
    input logic [NUM_ELEM*CNT_W-1:0] result_o
);
    logic [NUM_ELEM-1:0] mask_seen;
    logic [NUM_ELEM-1:0] len_seen;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_seen <= '0;
            len_seen  <= '0;
        end else if (start_i) begin
            mask_seen <= mask_i;
            for (int k = 0; k < NUM_ELEM; k++) begin
                len_seen[k] <= (VL_W'(k) < vl_i);
            end
        end
    end

    // R2
    valid_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> valid_o);

    // R2
    valid_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> !valid_o);

    // R9
    idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (wen_o == '0));

    // R5 R8
    masked_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ((wen_o & ~mask_seen) == '0));

    // R6
    beyond_len_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ((wen_o & ~len_seen) == '0));

    // R10
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(result_o));
endmodule

bind prefix_count_unit pcu_chk #(
    .NUM_ELEM(NUM_ELEM),
    .CNT_W   (CNT_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mask_i  (mask_i),
    .vl_i    (vl_i),
    .valid_o (valid_o),
    .wen_o   (wen_o),
    .result_o(result_o)
);

// File: tb/sim_prefix_count_unit.sv
module sim_prefix_count_unit;
    localparam int N = 8;
    localparam int W = 4;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        src_all_ones_i = 1'b0;
    logic [7:0]  src_bits_i = '0;
    logic [7:0]  mask_i = '0;
    logic [3:0]  vl_i = 4'd8;
    logic [31:0] cond_i = '0;
    logic [1:0]  sel_i = '0;
    logic        pol_i = 1'b0;
    logic [31:0] prev_i = '0;
    logic        valid_o;
    logic [7:0]  wen_o;
    logic [31:0] result_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_res;
    logic [7:0]  exp_wen;

    always #10 clk_i = ~clk_i;

    prefix_count_unit u0 (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
        .src_all_ones_i(src_all_ones_i), .src_bits_i(src_bits_i), .mask_i(mask_i),
        .vl_i(vl_i), .cond_i(cond_i), .sel_i(sel_i), .pol_i(pol_i), .prev_i(prev_i),
        .valid_o(valid_o), .wen_o(wen_o), .result_o(result_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // model built from the requirement text
    task automatic model();
        logic [7:0] src;
        int run;
        int cnt;
        exp_res = prev_i;
        exp_wen = '0;
        src = src_all_ones_i ? 8'hFF : src_bits_i;
        run = 0;
        for (int k = 0; k < N; k++) begin
            if (k < int'(vl_i)) begin
                if (mask_i[k]) begin
                    exp_wen[k] = 1'b1;
                    if (!mode_i) begin
                        cnt = 0;
                        for (int j = 0; j < k; j++) if (src[j] && mask_i[j]) cnt++;
                        exp_res[k*W +: W] = W'(cnt);
                    end else begin
                        exp_res[k*W +: W] = W'(run);
                        if (cond_i[k*4 + int'(sel_i)] == pol_i) run++;
                    end
                end else if (mode_i) begin
                    run = 0;
                end
            end
        end
    endtask

    // issue one request, check the outputs one cycle later, then the idle cycle
    task automatic run_op(input string req);
        logic [31:0] held;
        model();
        @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        chk("R2", {req, " valid"}, 32'(valid_o), 32'd1);
        chk(req, "wen", 32'(wen_o), 32'(exp_wen));
        chk(req, "result", result_o, exp_res);
        held = result_o;
        @(negedge clk_i);
        chk("R9", "idle wen", 32'(wen_o), 32'd0);
        chk("R2", "idle valid", 32'(valid_o), 32'd0);
        chk("R10", "held result", result_o, held);
    endtask

    task automatic t_reset();
        chk("R1", "valid", 32'(valid_o), 32'd0);
        chk("R1", "wen", 32'(wen_o), 32'd0);
        chk("R1", "result", result_o, 32'd0);
    endtask

    task automatic t_unmasked();
        mode_i = 0; src_all_ones_i = 0; src_bits_i = 8'b1001_0001;
        mask_i = 8'hFF; vl_i = 8; prev_i = 32'hFFFF_FFFF;
        run_op("R3");
        chk("R3", "literal", exp_res, 32'h2221_1110);
    endtask

    task automatic t_index();
        mode_i = 0; src_all_ones_i = 1; src_bits_i = 8'h00;
        mask_i = 8'hFF; vl_i = 8; prev_i = 32'h0;
        run_op("R4");
        chk("R4", "literal", exp_res, 32'h7654_3210);
        vl_i = 5; prev_i = 32'hAAAA_AAAA;
        run_op("R6");
        chk("R6", "literal", exp_res, 32'hAAA4_3210);
        src_all_ones_i = 0;
    endtask

    task automatic t_masked();
        mode_i = 0; src_bits_i = 8'b1001_0001; mask_i = 8'b1110_1011;
        vl_i = 8; prev_i = 32'h2345_6789;
        run_op("R5");
        chk("R5", "literal", exp_res, 32'h1115_1710);
    endtask

    task automatic t_chain();
        mode_i = 1; mask_i = 8'hFF; vl_i = 8; sel_i = 2; pol_i = 1;
        cond_i = 32'h0040_0440; prev_i = 32'h0;
        run_op("R7");
        chk("R7", "literal", exp_res, 32'h3322_2100);
    endtask

    task automatic t_chain_clear();
        mode_i = 1; mask_i = 8'b1111_0111; vl_i = 8; sel_i = 0; pol_i = 0;
        cond_i = 32'h0; prev_i = 32'h9999_9999;
        run_op("R8");
        chk("R8", "literal", exp_res, 32'h3210_9210);
        vl_i = 3; mask_i = 8'hFF; prev_i = 32'h5555_5555;
        run_op("R6");
        chk("R6", "literal", exp_res, 32'h5555_5210);
    endtask

    task automatic t_mixed();
        logic [31:0] lfsr = 32'hACE1_1234;
        for (int n = 0; n < 24; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            mode_i = lfsr[0];
            src_all_ones_i = (lfsr[7:5] == 3'd0);
            src_bits_i = lfsr[15:8];
            mask_i = lfsr[23:16] | 8'h11;
            vl_i = 4'(1 + (lfsr[26:24] % 8));
            sel_i = lfsr[28:27];
            pol_i = lfsr[29];
            cond_i = {lfsr[15:0], lfsr[31:16]};
            prev_i = ~lfsr;
            run_op(mode_i ? "R7" : "R5");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_unmasked();
        t_index();
        t_masked();
        t_chain();
        t_chain_clear();
        t_mixed();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule